// File: doc/BRIEF.md
# Video Control Transition Filter

This block conditions three video control levels (data-enable, horizontal sync and vertical sync style signals) in the parallel clock domain of a serial link transmitter, before they are packed into a frame. Every control lane has a budget of output transitions inside a sliding window of 130 clock edges. A lane may also need a new input level to persist for a minimum number of edges before the output follows. A transition that is refused leaves the output at its old level and raises a one-cycle drop flag for that lane.

A two-bit configuration input picks the operating mode. In the two normal modes the first two lanes ("fast" lanes) allow two transitions per window, and the optional three-edge width filter is applied to them. The third lane ("slow" lane) allows one transition per window and always needs a 130-edge pulse width. A legacy mode passes all three levels through a single register with no limiting. Changing the mode wipes the history, so the new mode starts with a full budget.

Top module: `vidctl_filter`

## Requirements
- R1: A synchronous active-high reset drives `ctrlOut` and `dropFlag` to zero, clears all width counts and makes the full transition budget of every lane available.
- R2: `cfgMode` encoding: 2'b00 is normal with the width filter off, 2'b01 is normal with the width filter on, and 2'b10 and 2'b11 are both legacy pass-through.
- R3: In legacy mode `ctrlOut` equals `ctrlIn` from the previous clock edge, and `dropFlag` stays zero. No rate or width limit applies.
- R4: In a normal mode a fast lane (`ctrlIn[0]` and `ctrlIn[1]`) accepts a transition at edge t only if its second most recent accepted transition happened at edge t-130 or earlier.
- R5: In mode 2'b01 a fast lane changes its output at the third consecutive edge that samples an input different from the output. Pulses of one or two cycles leave the output unchanged and raise no drop flag.
- R6: In mode 2'b00 a fast lane changes its output at the first edge that samples an input different from the output, provided budget is left.
- R7: In both normal modes the slow lane (`ctrlIn[2]`) changes its output at the 130th consecutive edge that samples a differing input. It accepts a transition only if its previous accepted transition happened at edge t-130 or earlier.
- R8: When a transition meets its width but the budget is spent, the output holds and that lane's `dropFlag` bit is high for the following cycle. The width count then restarts, so an input that stays different tries again after another full minimum width.
- R9: At the first edge that samples a new `cfgMode` value, all outputs hold and `dropFlag` goes to zero. Width counts and transition history are cleared at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgMode | input | 2 | Mode select (see R2) |
| ctrlIn | input | 3 | Raw control levels; bits 0 and 1 fast lanes, bit 2 slow lane |
| ctrlOut | output | 3 | Filtered control levels |
| dropFlag | output | 3 | One-cycle pulse per lane for each refused transition |

## Verification
A corrupted window age shows up at the ports on the very next transition attempt in the affected lane. Either `dropFlag` rises on a transition that had budget left, or a third fast-lane edge slips through within 130 cycles. A wrong width count shifts the output edge away from the third sampled edge (fast lanes) or the 130th (slow lane), so the error is visible within that many cycles of the input change. Missing clear logic on a mode change shows up within one window, as a drop right after the switch.

// File: rtl/vidctl_filter_pkg.sv
package vidctl_filter_pkg;

  localparam logic [1:0] MODE_RAW   = 2'b00;
  localparam logic [1:0] MODE_WIDTH = 2'b01;

  typedef struct packed {
    logic clearHist;
    logic bypass;
    logic widthOn;
  } filtStrobe_t;

endpackage

// File: rtl/vidctl_filter_ctrl.sv
module vidctl_filter_ctrl
  import vidctl_filter_pkg::*;
(
  input  logic        clk,
  input  logic [1:0]  cfgMode,
  output filtStrobe_t strobe
);

  logic [1:0] cfgPrev;

  always_ff @(posedge clk) begin
    cfgPrev <= cfgMode;
  end

  always_comb begin
    strobe.clearHist = (cfgMode != cfgPrev);
    strobe.bypass    = cfgMode[1];
    strobe.widthOn   = (cfgMode == MODE_WIDTH);
  end

endmodule

// File: rtl/vidctl_filter_lane.sv
module vidctl_filter_lane
  import vidctl_filter_pkg::*;
#(
  parameter int WINDOW  = 130,
  parameter int BUDGET  = 2,
  parameter int MIN_ON  = 3,
  parameter int MIN_OFF = 1
)
(
  input  logic        clk,
  input  logic        rst,
  input  filtStrobe_t strobe,
  input  logic        din,
  output logic        dout,
  output logic        drop
);

  localparam int MAXMIN = (MIN_ON > MIN_OFF) ? MIN_ON : MIN_OFF;
  localparam int RW     = $clog2(MAXMIN + 1);
  localparam int RW1    = RW + 1;
  localparam int AW     = $clog2(WINDOW + 1);

  logic [RW-1:0] runLen;
  logic [AW-1:0] age [BUDGET];
  logic [RW:0]   runPlus;
  logic [RW:0]   minW;
  logic          differ;
  logic          candidate;
  logic          allowed;

  function automatic logic [AW-1:0] ageStep(input logic [AW-1:0] a);
    return (a >= AW'(WINDOW)) ? AW'(WINDOW) : a + 1'b1;
  endfunction

  always_comb begin
    runPlus   = {1'b0, runLen} + 1'b1;
    minW      = strobe.widthOn ? RW1'(MIN_ON) : RW1'(MIN_OFF);
    differ    = (din != dout);
    candidate = differ && (runPlus >= minW);
    allowed   = (age[BUDGET-1] >= AW'(WINDOW));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout   <= 1'b0;
      drop   <= 1'b0;
      runLen <= '0;
      for (int j = 0; j < BUDGET; j++) age[j] <= AW'(WINDOW);
    end else begin
      drop <= 1'b0;
      if (strobe.clearHist) begin
        runLen <= '0;
        for (int j = 0; j < BUDGET; j++) age[j] <= AW'(WINDOW);
      end else if (strobe.bypass) begin
        dout   <= din;
        runLen <= '0;
        for (int j = 0; j < BUDGET; j++) age[j] <= ageStep(age[j]);
      end else if (!differ) begin
        runLen <= '0;
        for (int j = 0; j < BUDGET; j++) age[j] <= ageStep(age[j]);
      end else if (!candidate) begin
        runLen <= runPlus[RW-1:0];
        for (int j = 0; j < BUDGET; j++) age[j] <= ageStep(age[j]);
      end else begin
        runLen <= '0;
        if (allowed) begin
          dout   <= din;
          age[0] <= AW'(1);
          for (int j = BUDGET - 1; j > 0; j--) age[j] <= ageStep(age[j-1]);
        end else begin
          drop <= 1'b1;
          for (int j = 0; j < BUDGET; j++) age[j] <= ageStep(age[j]);
        end
      end
    end
  end

endmodule

// File: rtl/vidctl_filter.sv
module vidctl_filter
  import vidctl_filter_pkg::*;
#(
  parameter int NUM_CTRL    = 3,
  parameter int WINDOW      = 130,
  parameter int FAST_BUDGET = 2,
  parameter int SLOW_BUDGET = 1,
  parameter int FAST_MIN    = 3,
  parameter int SLOW_MIN    = 130
)
(
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          cfgMode,
  input  logic [NUM_CTRL-1:0] ctrlIn,
  output logic [NUM_CTRL-1:0] ctrlOut,
  output logic [NUM_CTRL-1:0] dropFlag
);

  localparam int SLOW_LANE = NUM_CTRL - 1;

  filtStrobe_t strobe;

  vidctl_filter_ctrl u_ctrl (
    .clk     (clk),
    .cfgMode (cfgMode),
    .strobe  (strobe)
  );

  for (genvar g = 0; g < NUM_CTRL; g++) begin : g_lane
    if (g < SLOW_LANE) begin : g_fast
      vidctl_filter_lane #(
        .WINDOW (WINDOW), .BUDGET (FAST_BUDGET),
        .MIN_ON (FAST_MIN), .MIN_OFF (1)
      ) u_lane (
        .clk (clk), .rst (rst), .strobe (strobe),
        .din (ctrlIn[g]), .dout (ctrlOut[g]), .drop (dropFlag[g])
      );
    end else begin : g_slow
      vidctl_filter_lane #(
        .WINDOW (WINDOW), .BUDGET (SLOW_BUDGET),
        .MIN_ON (SLOW_MIN), .MIN_OFF (SLOW_MIN)
      ) u_lane (
        .clk (clk), .rst (rst), .strobe (strobe),
        .din (ctrlIn[g]), .dout (ctrlOut[g]), .drop (dropFlag[g])
      );
    end
  end

endmodule

// File: rtl/vidctl_filter_checker.sv
module vidctl_filter_checker #(
  parameter int NUM_CTRL = 3
)
(
  input logic                clk,
  input logic                rst,
  input logic [1:0]          cfgMode,
  input logic [NUM_CTRL-1:0] ctrlIn,
  input logic [NUM_CTRL-1:0] ctrlOut,
  input logic [NUM_CTRL-1:0] dropFlag
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (ctrlOut == '0 && dropFlag == '0)); // R1

  AST_LEGACY_ECHO: assert property (@(posedge clk) disable iff (rst)
    (cfgMode[1] && $stable(cfgMode)) |=> (ctrlOut == $past(ctrlIn) && dropFlag == '0)); // R3

  AST_WIDTH_THREE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !$past(rst, 3) && $past(cfgMode) == 2'b01
      && ctrlOut[0] != $past(ctrlOut[0]))
    |-> ($past(ctrlIn[0], 1) == ctrlOut[0] && $past(ctrlIn[0], 2) == ctrlOut[0]
         && $past(ctrlIn[0], 3) == ctrlOut[0])); // R5

  AST_DROP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (dropFlag != '0) |-> ((dropFlag & (ctrlOut ^ $past(ctrlOut))) == '0)); // R8

  AST_MODE_SWITCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfgMode) |=> ($stable(ctrlOut) && dropFlag == '0)); // R9

endmodule

bind vidctl_filter vidctl_filter_checker #(.NUM_CTRL(NUM_CTRL)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfgMode  (cfgMode),
  .ctrlIn   (ctrlIn),
  .ctrlOut  (ctrlOut),
  .dropFlag (dropFlag)
);

// File: tb/vidctl_filter_bench.sv
`timescale 1ns/1ps
module vidctl_filter_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cfg = 2'b00;
  logic [2:0] din = 3'b000;
  logic [2:0] dout;
  logic [2:0] drop;

  int total = 0;
  int bad   = 0;
  string curReq = "R1";

  always #2.5 clk = ~clk;

  vidctl_filter u_vidctl_filter (
    .clk (clk), .rst (rst), .cfgMode (cfg),
    .ctrlIn (din), .ctrlOut (dout), .dropFlag (drop)
  );

  // reference model, stamp based
  logic [2:0] mOut  = 3'b000;
  logic [2:0] mDrop = 3'b000;
  logic [1:0] mCfgPrev = 2'b00;
  int mRun [3];
  int mStamp [3][2];
  int cyc = 0;

  function automatic int minWidth(int lane, logic [1:0] c);
    if (lane == 2) return 130;
    return (c == 2'b01) ? 3 : 1;
  endfunction

  function automatic int budget(int lane);
    return (lane == 2) ? 1 : 2;
  endfunction

  task automatic clearModel();
    for (int l = 0; l < 3; l++) begin
      mRun[l] = 0;
      mStamp[l][0] = -1000000;
      mStamp[l][1] = -1000000;
    end
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst) begin
      mOut = 3'b000; mDrop = 3'b000; clearModel();
    end else if (cfg != mCfgPrev) begin
      mDrop = 3'b000; clearModel();
    end else if (cfg[1]) begin
      mOut = din; mDrop = 3'b000;
    end else begin
      mDrop = 3'b000;
      for (int l = 0; l < 3; l++) begin
        if (din[l] == mOut[l]) mRun[l] = 0;
        else if (mRun[l] + 1 < minWidth(l, cfg)) mRun[l] = mRun[l] + 1;
        else begin
          mRun[l] = 0;
          if (cyc - mStamp[l][budget(l) - 1] >= 130) begin
            mStamp[l][1] = mStamp[l][0];
            mStamp[l][0] = cyc;
            mOut[l] = din[l];
          end else mDrop[l] = 1'b1;
        end
      end
    end
    mCfgPrev = cfg;
  end

  task automatic chk(string req, string what, logic [2:0] act, logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk(curReq, "ctrlOut", dout, mOut);
    chk(curReq, "dropFlag", drop, mDrop);
  endtask

  task automatic randomRun(int n, int fastOdds, int slowOdds);
    for (int i = 0; i < n; i++) begin
      tick();
      for (int l = 0; l < 2; l++)
        if ($urandom_range(fastOdds - 1) == 0) din[l] = ~din[l];
      if ($urandom_range(slowOdds - 1) == 0) din[2] = ~din[2];
    end
  endtask

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state
    repeat (4) tick();
    chk("R1", "reset out", dout, 3'b000);
    chk("R1", "reset drop", drop, 3'b000);
    rst = 1'b0;
    tick();

    // R6: mode 00 single-edge response
    curReq = "R6";
    din = 3'b010; tick();
    chk("R6", "fast lane follows in one edge", dout, 3'b010);

    // R8: third lane-0 transition inside window is dropped
    curReq = "R8";
    din = 3'b011; tick();
    chk("R8", "first accept", dout, 3'b011);
    din = 3'b010; tick();
    chk("R8", "second accept", dout, 3'b010);
    din = 3'b011; tick();
    chk("R8", "third held", dout, 3'b010);
    chk("R8", "drop pulse", drop, 3'b001);
    din = 3'b010; tick();
    chk("R8", "drop clears", drop, 3'b000);
    repeat (135) tick();

    // R7: slow lane needs 130 edges
    curReq = "R7";
    din = 3'b110;
    repeat (129) tick();
    chk("R7", "slow lane before 130", dout, 3'b010);
    tick();
    chk("R7", "slow lane at 130", dout, 3'b110);

    // R9 + R5: switch to width mode
    curReq = "R9";
    cfg = 2'b01; tick();
    chk("R9", "hold on switch", dout, 3'b110);
    chk("R9", "no drop on switch", drop, 3'b000);
    curReq = "R5";
    din = 3'b111; tick(); din = 3'b110; tick(); tick();
    chk("R5", "one-cycle pulse ignored", dout, 3'b110);
    din = 3'b111; tick(); tick(); din = 3'b110; tick(); tick();
    chk("R5", "two-cycle pulse ignored", dout, 3'b110);
    chk("R5", "no drop for short pulse", drop, 3'b000);
    din = 3'b111; tick(); tick();
    chk("R5", "held level after two edges", dout, 3'b110);
    tick();
    chk("R5", "held level at third edge", dout, 3'b111);

    // R9: mode switch clears history, next edge uses mode 00
    curReq = "R9";
    din = 3'b101; cfg = 2'b00; tick();
    chk("R9", "hold at switch edge", dout, 3'b111);
    tick();
    chk("R9", "fresh budget after switch", dout, 3'b101);

    // R2: 2'b11 is legacy pass-through
    curReq = "R2";
    cfg = 2'b11; tick();
    din = 3'b010; tick();
    chk("R2", "legacy echo", dout, 3'b010);

    // random phases
    curReq = "R3"; cfg = 2'b10; randomRun(600, 2, 3);
    curReq = "R3"; cfg = 2'b11; randomRun(600, 2, 3);
    curReq = "R4"; cfg = 2'b00; randomRun(2500, 8, 150);
    curReq = "R5"; cfg = 2'b01; randomRun(2500, 3, 150);
    curReq = "R7"; cfg = 2'b00; randomRun(1500, 40, 90);
    curReq = "R9";
    for (int k = 0; k < 40; k++) begin
      cfg = 2'($urandom_range(3));
      randomRun(int'($urandom_range(60, 5)), 4, 50);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule